// File: doc/BRIEF.md
# Legacy NMI Status and Control Port

This block is a byte-wide I/O register that collects two non-maskable interrupt sources and drives a single NMI request. The first source is a PCI system-error pulse, and the block latches it on a rising edge. The second source is an ISA channel-check line, and the block latches it while that line is high. Each source has an active-low enable bit. Setting that bit to 1 masks the source and also clears its latched status, so software acknowledges an event by writing 1 to the bit and then writing 0.

The same register gives two further signals:
- **Timer channel 2.** Read-only status bits show the live output of interval-timer channel 2. Two writable bits drive that channel's gate and a speaker output. The speaker output is the timer output gated by its enable bit.
- **Refresh toggle.** A free-running toggle bit changes state once per refresh interval. A prescaler produces it from the system clock.

The port decodes a single I/O address. Reads return the assembled byte in the same cycle and need no handshake. Writes take effect at the next clock edge.

Top module: `nmi_port_ctl`

## Requirements
- R1: After reset, all four control bits are 0. The NMI, gate and speaker outputs are 0. A read returns 00h while the timer input is low.
- R2: A write decoded at PORT_ADDR stores write bits 3:0 as the control bits, and a later read returns them in bits 3:0. Write bits 7:4 have no effect on any state.
- R3: The gate output equals control bit 0. The speaker output is 0 when control bit 1 is 0, and follows the timer input when control bit 1 is 1.
- R4: While control bit 2 is 0, a rising edge on the SERR input sets read bit 7 within three clock edges. A SERR input that stays high does not set the bit again after it is cleared.
- R5: While control bit 2 is 1, read bit 7 is 0 from the next edge onward and SERR edges are ignored.
- R6: While control bit 3 is 0, a high IOCHK input sets read bit 6 within three clock edges. While control bit 3 is 1, bit 6 is held at 0. If the input is still high when bit 3 returns to 0, bit 6 sets again.
- R7: The NMI output is high exactly when read bit 7 or read bit 6 is 1.
- R8: Read bit 5 shows the current level of the timer input.
- R9: Read bit 4 inverts every REFRESH_DIV clock cycles.
- R10: Writes at any other address change nothing. The read data is 00h unless a read is decoded at PORT_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| serr_i | input | 1 | PCI system-error pulse, asynchronous |
| iochk_i | input | 1 | ISA channel-check level, asynchronous |
| tmr2_out_i | input | 1 | Interval-timer channel 2 output |
| nmi_o | output | 1 | NMI request |
| tmr2_gate_o | output | 1 | Timer channel 2 gate enable |
| spkr_o | output | 1 | Speaker drive |

## Verification
Either status flag can be wrong while its enable bit is set, or after an edge while it is clear. Such a flag shows on nmi_o and in read bits 7:6 no more than three edges after the stimulus. The bench compares against a model at that point after every action. A SERR edge detector that retriggers shows up only when the SERR input is held high across an acknowledge, so a directed case covers it. A prescaler off by one cycle shows in the first measured toggle interval. A control write that leaks bits or decodes the wrong address shows on the next read-back.

// File: rtl/nmi_port_pkg.sv
package nmi_port_pkg;
  localparam int BIT_SERR_STS  = 7;
  localparam int BIT_IOCHK_STS = 6;
  localparam int BIT_TMR2_OUT  = 5;
  localparam int BIT_REFRESH   = 4;
  localparam int BIT_IOCHK_DIS = 3;
  localparam int BIT_SERR_DIS  = 2;
  localparam int BIT_SPKR_EN   = 1;
  localparam int BIT_GATE_EN   = 0;

  // Only the low nibble of a write is kept; the status half is read-only.
  function automatic logic [3:0] ctrl_from_write(input logic [7:0] d);
    logic [3:0] c;
    c = d[3:0];
    return c;
  endfunction

  function automatic logic [7:0] pack_read(input logic serr_sts, input logic iochk_sts,
                                           input logic tmr2, input logic refresh,
                                           input logic [3:0] ctrl);
    logic [7:0] v;
    v = {serr_sts, iochk_sts, tmr2, refresh, ctrl};
    return v;
  endfunction
endpackage

// File: rtl/nmi_in_sync.sv
module nmi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      prev  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], async_i};
      prev  <= shreg[STAGES-1];
    end
  end

  assign level_o = shreg[STAGES-1];
  assign rise_o  = shreg[STAGES-1] & ~prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/nmi_src_latch.sv
module nmi_src_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  output logic sts_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     sts_o <= 1'b0;
    else if (clr_i) sts_o <= 1'b0;
    else if (set_i) sts_o <= 1'b1;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !sts_o); // R5 R6
  AST_SET_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_o) |-> $past(set_i)); // R4
endmodule

// File: rtl/nmi_refresh_tick.sv
module nmi_refresh_tick #(
  parameter int REFRESH_DIV = 1500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tog_o
);
  localparam int CNT_W = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tog_o <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      tog_o <= ~tog_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TOGGLE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog_o) |-> $past(cnt) == LAST); // R9
endmodule

// File: rtl/nmi_port_ctl.sv
module nmi_port_ctl
  import nmi_port_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(16'h0061),
  parameter int              REFRESH_DIV = 1500,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              serr_i,
  input  logic              iochk_i,
  input  logic              tmr2_out_i,
  output logic              nmi_o,
  output logic              tmr2_gate_o,
  output logic              spkr_o
);
  logic       addr_hit, wr_hit, rd_hit;
  logic [3:0] ctrl;
  logic       serr_rise, serr_lvl_unused;
  logic       iochk_lvl, iochk_rise_unused;
  logic       serr_sts, iochk_sts, refresh_tog;
  logic       serr_dis, iochk_dis;

  assign addr_hit = (io_addr == PORT_ADDR);
  assign wr_hit   = io_wr & addr_hit;
  assign rd_hit   = io_rd & addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl <= '0;
    else if (wr_hit) ctrl <= ctrl_from_write(io_wdata);
  end

  assign serr_dis  = ctrl[BIT_SERR_DIS];
  assign iochk_dis = ctrl[BIT_IOCHK_DIS];

  nmi_in_sync #(.STAGES(SYNC_STAGES)) u_serr_sync (
    .clk(clk), .rst_n(rst_n), .async_i(serr_i),
    .level_o(serr_lvl_unused), .rise_o(serr_rise));

  nmi_in_sync #(.STAGES(SYNC_STAGES)) u_iochk_sync (
    .clk(clk), .rst_n(rst_n), .async_i(iochk_i),
    .level_o(iochk_lvl), .rise_o(iochk_rise_unused));

  nmi_src_latch u_serr_latch (
    .clk(clk), .rst_n(rst_n), .clr_i(serr_dis), .set_i(serr_rise), .sts_o(serr_sts));

  nmi_src_latch u_iochk_latch (
    .clk(clk), .rst_n(rst_n), .clr_i(iochk_dis), .set_i(iochk_lvl), .sts_o(iochk_sts));

  nmi_refresh_tick #(.REFRESH_DIV(REFRESH_DIV)) u_refresh (
    .clk(clk), .rst_n(rst_n), .tog_o(refresh_tog));

  assign nmi_o       = serr_sts | iochk_sts;
  assign tmr2_gate_o = ctrl[BIT_GATE_EN];
  assign spkr_o      = ctrl[BIT_SPKR_EN] & tmr2_out_i;
  assign io_rdata    = rd_hit ? pack_read(serr_sts, iochk_sts, tmr2_out_i, refresh_tog, ctrl)
                              : 8'h00;

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctrl)); // R2
  AST_SERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    serr_dis |=> !nmi_o || iochk_sts); // R5
  AST_IOCHK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    iochk_dis |=> !io_rdata[BIT_IOCHK_STS]); // R6
  AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(serr_rise) || $past(iochk_lvl)); // R7
endmodule

// File: tb/test_nmi_port_ctl.sv
module test_nmi_port_ctl;
  localparam int DIV = 1500;
  localparam logic [15:0] PA = 16'h0061;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic serr_i = 1'b0, iochk_i = 1'b0, tmr2_out_i = 1'b0;
  logic nmi_o, tmr2_gate_o, spkr_o;

  int checks = 0, failures = 0;

  // bench model
  logic [3:0] m_ctrl = '0;
  logic m_serr = 1'b0, m_iochk = 1'b0;

  nmi_port_ctl #(.REFRESH_DIV(DIV)) i_nmi_port_ctl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .serr_i(serr_i), .iochk_i(iochk_i),
    .tmr2_out_i(tmr2_out_i), .nmi_o(nmi_o), .tmr2_gate_o(tmr2_gate_o), .spkr_o(spkr_o));

  always #5 clk = ~clk;

  function automatic logic [7:0] model_byte();
    logic [7:0] b = 8'h00;
    b[7] = m_serr; b[6] = m_iochk; b[5] = tmr2_out_i;
    b[3] = m_ctrl[3]; b[2] = m_ctrl[2]; b[1] = m_ctrl[1]; b[0] = m_ctrl[0];
    return b;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic model_write(input logic [7:0] d);
    io_write(PA, d);
    m_ctrl = d[3:0];
    if (m_ctrl[2]) m_serr = 1'b0;
    if (m_ctrl[3]) m_iochk = 1'b0;
    else if (iochk_i) m_iochk = 1'b1;
  endtask

  task automatic compare_all(input string tag);
    logic [7:0] rd;
    cyc(4);
    io_read(PA, rd);
    check({tag, " read"}, rd & 8'hEF, model_byte());
    check("R7 nmi", {7'd0, nmi_o}, {7'd0, m_serr | m_iochk});
    check("R3 gate", {7'd0, tmr2_gate_o}, {7'd0, m_ctrl[0]});
    check("R3 spkr", {7'd0, spkr_o}, {7'd0, m_ctrl[1] & tmr2_out_i});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [7:0] rd;
    int unsigned seed;
    seed = $urandom(32'd2024);
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    io_read(PA, rd);
    check("R1 reset read", rd, 8'h00);
    check("R1 reset outs", {5'd0, nmi_o, tmr2_gate_o, spkr_o}, 8'h00);

    // R2 high write bits ignored, low bits stored
    model_write(8'hF3);
    compare_all("R2");

    // R10 other address write and non-decoded reads
    io_write(16'h0060, 8'h0C);
    io_read(PA, rd);
    check("R10 foreign write", rd & 8'h0F, {4'd0, m_ctrl});
    io_read(16'h0060, rd);
    check("R10 foreign read", rd, 8'h00);
    #1 check("R10 idle rdata", io_rdata, 8'h00);

    // R4 SERR pulse latches, held-high input does not relatch
    model_write(8'h00);
    @(negedge clk) serr_i = 1'b1;
    m_serr = 1'b1;
    compare_all("R4 latch");
    model_write(8'h04);
    compare_all("R5 clear");
    model_write(8'h00);
    compare_all("R4 no relatch");
    @(negedge clk) serr_i = 1'b0;
    // R5 edge while disabled ignored
    model_write(8'h04);
    @(negedge clk) serr_i = 1'b1;
    @(negedge clk) serr_i = 1'b0;
    compare_all("R5 masked edge");

    // R6 IOCHK level, relatch on re-enable
    model_write(8'h00);
    @(negedge clk) iochk_i = 1'b1;
    m_iochk = 1'b1;
    compare_all("R6 latch");
    model_write(8'h08);
    compare_all("R6 held clear");
    model_write(8'h00);
    compare_all("R6 relatch");
    @(negedge clk) iochk_i = 1'b0;
    model_write(8'h08);
    model_write(8'h00);
    compare_all("R6 acked");

    // R8/R3 timer pass-through
    model_write(8'h02);
    @(negedge clk) tmr2_out_i = 1'b1;
    compare_all("R8 tmr high");
    model_write(8'h00);
    compare_all("R3 spkr off");

    // random phase
    for (int it = 0; it < 300; it++) begin
      int unsigned act;
      act = $urandom_range(0, 4);
      case (act)
        0: model_write(8'($urandom()));
        1: begin @(negedge clk) tmr2_out_i = 1'($urandom()); end
        2: begin
             @(negedge clk) serr_i = 1'b1;
             @(negedge clk) serr_i = 1'b0;
             if (!m_ctrl[2]) m_serr = 1'b1;
           end
        3: begin
             @(negedge clk) iochk_i = 1'($urandom());
             if (iochk_i && !m_ctrl[3]) m_iochk = 1'b1;
           end
        default: io_write(16'($urandom_range(0, 16'h0060)), 8'($urandom()));
      endcase
      compare_all("R2 R4 R6 R8 random");
    end

    // R9 refresh toggle interval
    begin
      logic prev;
      int cnt;
      @(negedge clk);
      io_addr = PA; io_rd = 1'b1;
      #1 prev = io_rdata[4];
      while (io_rdata[4] == prev) begin @(negedge clk); #1; end
      prev = io_rdata[4];
      cnt = 0;
      while (io_rdata[4] == prev && cnt < 3 * DIV) begin @(negedge clk); #1; cnt++; end
      io_rd = 1'b0;
      check("R9 toggle period", 8'(cnt / 10), 8'(DIV / 10));
      checks++;
      if (cnt != DIV) begin
        failures++;
        $display("FAIL R9 period actual=%0d expected=%0d", cnt, DIV);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule